// File: doc/BRIEF.md
# Oversampling asynchronous serial receiver

This block turns an asynchronous serial line carrying 8N1 characters into parallel bytes. The line idles high. Each character is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. Every complete character is presented on `rx_data` with a single-cycle `rx_valid` strobe. A character whose stop bit reads low raises a single-cycle `frame_err` strobe instead.

Timing comes from a 32-bit phase accumulator. On every clock it adds the programmable `phase_inc`, and each carry out of the top bit is one oversampling tick. Eight ticks make one bit period, so `phase_inc = round(8 * baud * 2^32 / f_clk)`. This reaches any common rate between 9600 and 115200 baud from system clocks between roughly 12 MHz and 100 MHz.

The raw pin passes through a two-flop synchronizer, and only its output is used. Each bit is decided by a 2-of-3 vote over the oversamples at positions 3, 4 and 5 of the eight in that bit. Any state register value outside the defined states returns the receiver to idle on the next clock.

Top module: `uart_os_rx`

## Requirements
- R1: `rx_raw` is captured by exactly one flop, and a second flop follows it. Only the second flop's output drives the receive logic, so a line change becomes visible to the logic two clocks later.
- R2: An 8N1 character, with a low start bit, eight data bits least significant bit first and a high stop bit, appears on `rx_data` together with a one-cycle `rx_valid` pulse.
- R3: Each clock adds `phase_inc` to a 32-bit accumulator, and a carry out gives one oversampling tick. A bit lasts eight ticks, so the received bit rate is `phase_inc * f_clk / 2^35`.
- R4: Each bit value is the majority of the samples taken at tick positions 3, 4 and 5 of that bit. A disturbance that reaches only one of those samples has no effect on the received byte.
- R5: A falling edge whose start-bit vote reads high is treated as a false start. The receiver returns to idle and produces neither `rx_valid` nor `frame_err`.
- R6: If the stop-bit vote reads low, `frame_err` pulses for one cycle, `rx_valid` stays low, and `rx_data` keeps its previous value.
- R7: A state register value outside the four defined states is replaced by the idle state on the next clock, and reception then works normally.
- R8: `rx_valid` and `frame_err` are never high together, and each is high for at most one consecutive cycle.
- R9: While synchronous reset `rst` is high, and in the first cycle after it, `rx_valid`, `frame_err` and `rx_data` are all zero.
- R10: A start bit that directly follows the previous stop bit, with no idle time between, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_raw | input | 1 | Asynchronous serial line, idles high |
| phase_inc | input | 32 | Phase accumulator increment that sets the oversampling tick rate |
| rx_data | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` carries a new byte |
| frame_err | output | 1 | One-cycle strobe when a stop bit reads low |

## Verification
The bench programs many bit lengths, with increments that are not powers of two, so a tick generator that loses its fractional carry drifts and corrupts the later bits. A receiver that sampled at bit edges would fail the same way.

It also places a short glitch at the centre of a data bit. A design that used a single sample, or voted at the wrong positions, would flip that bit.

Further directed cases cover the following:
- A short low pulse on an idle line. A design without the start-bit check would produce spurious bytes.
- A low stop bit. A design that got this wrong would deliver the byte or leave `rx_data` corrupted.
- Characters sent back to back. A receiver that finished the stop bit too late would miss the next start edge.
- A forced illegal state. A receiver with no recovery path would stay locked up.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int unsigned ST_W = 3;
  localparam logic [ST_W-1:0] ST_IDLE  = 3'd0;
  localparam logic [ST_W-1:0] ST_START = 3'd1;
  localparam logic [ST_W-1:0] ST_DATA  = 3'd2;
  localparam logic [ST_W-1:0] ST_STOP  = 3'd3;

  // 2-of-3 majority
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic st_legal(input logic [ST_W-1:0] s);
    return (s == ST_IDLE) || (s == ST_START) || (s == ST_DATA) || (s == ST_STOP);
  endfunction
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];

  // cycles since reset, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (q_sync == $past(d_async, 2))); // R1
endmodule

// File: rtl/uart_os_rx_tickgen.sv
module uart_os_rx_tickgen #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] phase_inc,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  assign sum = {1'b0, acc_q} + {1'b0, phase_inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  assign tick = tick_q;

  // a tick means the accumulator wrapped: what remains is below the step
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tick_q) |-> (acc_q < $past(phase_inc))); // R3
  AST_NO_TICK_GROW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !tick_q) |-> (acc_q >= $past(phase_inc))); // R3
endmodule

// File: rtl/uart_os_rx_core.sv
module uart_os_rx_core
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned OS     = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_s,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int unsigned OS_W  = $clog2(OS);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0]  POS_A   = OS_W'(OS/2 - 1);
  localparam logic [OS_W-1:0]  POS_B   = OS_W'(OS/2);
  localparam logic [OS_W-1:0]  POS_C   = OS_W'(OS/2 + 1);
  localparam logic [OS_W-1:0]  POS_END = OS_W'(OS - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

  logic [ST_W-1:0]   state_q;
  logic [OS_W-1:0]   pos_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        smp_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, ferr_q;

  // named events
  logic active, decide_pt, bit_end, vote_bit, start_seen;
  assign active     = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);
  assign decide_pt  = tick && active && (pos_q == POS_C);
  assign bit_end    = tick && active && (pos_q == POS_END);
  assign vote_bit   = maj3(smp_q[0], smp_q[1], rx_s);
  assign start_seen = tick && (state_q == ST_IDLE) && !rx_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      idx_q   <= '0;
      smp_q   <= '1;
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      if (tick && active) begin
        pos_q <= pos_q + 1'b1;
        if (pos_q == POS_A) smp_q[0] <= rx_s;
        if (pos_q == POS_B) smp_q[1] <= rx_s;
      end
      case (state_q)
        ST_IDLE: begin
          if (start_seen) begin
            state_q <= ST_START;
            pos_q   <= OS_W'(1);
          end
        end
        ST_START: begin
          if (decide_pt && vote_bit) state_q <= ST_IDLE;
          else if (bit_end) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA: begin
          if (decide_pt) shreg_q <= {vote_bit, shreg_q[DATA_W-1:1]};
          if (bit_end) begin
            if (idx_q == IDX_END) state_q <= ST_STOP;
            else                  idx_q   <= idx_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (decide_pt) begin
            state_q <= ST_IDLE;
            if (vote_bit) begin
              valid_q <= 1'b1;
              data_q  <= shreg_q;
            end else begin
              ferr_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign ferr  = ferr_q;

  AST_ILLEGAL_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !st_legal(state_q) |=> (state_q == ST_IDLE)); // R7
  AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_START) && decide_pt && vote_bit) |=> (state_q == ST_IDLE)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(valid_q && ferr_q)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R8
  AST_FERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    ferr_q |=> !ferr_q); // R8
  AST_FERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    ferr_q |-> $stable(data_q)); // R6
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned OS     = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_raw,
  input  logic [ACC_W-1:0]  phase_inc,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err
);
  logic rx_s;
  logic os_tick;

  uart_os_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_async(rx_raw), .q_sync(rx_s)
  );

  uart_os_rx_tickgen #(.ACC_W(ACC_W)) u_tick (
    .clk(clk), .rst(rst), .phase_inc(phase_inc), .tick(os_tick)
  );

  uart_os_rx_core #(.OS(OS), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tick(os_tick), .rx_s(rx_s),
    .data(rx_data), .valid(rx_valid), .ferr(frame_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!rx_valid && !frame_err && rx_data == '0)); // R9
endmodule

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_raw = 1'b1;
  logic [31:0] phase_inc = 32'h4000_0000;
  logic [7:0]  rx_data;
  logic        rx_valid, frame_err;

  int n_checks = 0;
  int n_errors = 0;
  int n_valid = 0, n_ferr = 0;
  logic [7:0] last_data = 8'h00;
  int bc = 32;

  always #2.5 clk = ~clk;

  uart_os_rx u_dut (
    .clk(clk), .rst(rst), .rx_raw(rx_raw), .phase_inc(phase_inc),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin n_valid++; last_data = rx_data; end
      if (frame_err) n_ferr++;
    end
  end

  function automatic logic [31:0] inc_for(input int bit_cycles);
    longint unsigned num;
    num = (64'd8 << 32) + longint'(bit_cycles / 2);
    return 32'(num / longint'(bit_cycles));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int cyc);
    rx_raw = lvl;
    repeat (cyc) @(posedge clk);
    #1;
  endtask

  // glitch_bit: data bit index to disturb with a sub-tick pulse, -1 for none
  task automatic send(input logic [7:0] d, input logic stop_hi, input int glitch_bit);
    hold(1'b0, bc);
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        int w;
        w = (bc / 16 < 1) ? 1 : bc / 16;
        hold(d[i], bc / 2);
        hold(~d[i], w);
        hold(d[i], bc - bc / 2 - w);
      end else begin
        hold(d[i], bc);
      end
    end
    hold(stop_hi, bc);
    rx_raw = 1'b1;
  endtask

  task automatic set_rate(input int bit_cycles);
    bc = bit_cycles;
    phase_inc = inc_for(bit_cycles);
    hold(1'b1, 2 * bit_cycles);
  endtask

  task automatic frame_check(input string req, input logic [7:0] d, input int glitch_bit);
    int v0, e0;
    v0 = n_valid; e0 = n_ferr;
    send(d, 1'b1, glitch_bit);
    hold(1'b1, 2 * bc);
    check(req, n_valid - v0, 1);
    check(req, n_ferr - e0, 0);
    check(req, last_data, d);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R9 valid", rx_valid, 0);
    check("R9 ferr", frame_err, 0);
    check("R9 data", rx_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after release", {rx_valid, frame_err, rx_data}, 0);

    // R2 / R3 directed at 32 cycles per bit (tick every 4 cycles)
    set_rate(32);
    frame_check("R2 0x00", 8'h00, -1);
    frame_check("R2 0xFF", 8'hFF, -1);
    frame_check("R2 LSB first 0x01", 8'h01, -1);
    frame_check("R2 LSB first 0x80", 8'h80, -1);
    frame_check("R2 0xA5", 8'hA5, -1);

    // R4 single-sample glitch at bit centre
    frame_check("R4 glitch b3", 8'h5A, 3);
    frame_check("R4 glitch b0", 8'hC3, 0);

    // R5 false start: short low pulse
    begin
      int v0, e0;
      v0 = n_valid; e0 = n_ferr;
      hold(1'b0, bc / 8);
      hold(1'b1, 3 * bc);
      check("R5 no valid", n_valid - v0, 0);
      check("R5 no ferr", n_ferr - e0, 0);
    end
    frame_check("R5 recover", 8'h3C, -1);

    // R6 framing error
    begin
      int v0, e0;
      v0 = n_valid; e0 = n_ferr;
      send(8'h77, 1'b0, -1);
      hold(1'b1, 3 * bc);
      check("R6 ferr pulse", n_ferr - e0, 1);
      check("R6 no valid", n_valid - v0, 0);
      check("R6 data kept", rx_data, 8'h3C);
    end

    // R10 back-to-back
    begin
      int v0;
      v0 = n_valid;
      send(8'h12, 1'b1, -1);
      send(8'h34, 1'b1, -1);
      hold(1'b1, 2 * bc);
      check("R10 two bytes", n_valid - v0, 2);
      check("R10 second byte", last_data, 8'h34);
    end

    // R7 illegal state recovery
    @(negedge clk);
    force u_dut.u_core.state_q = 3'b111;
    #1 release u_dut.u_core.state_q;
    hold(1'b1, 4);
    frame_check("R7 recover", 8'h99, -1);

    // R3 random rates (fractional increments) and data
    begin
      int unsigned seed_val;
      seed_val = $urandom(32'd1234);
      for (int k = 0; k < 40; k++) begin
        set_rate(16 + int'($urandom_range(48)));
        frame_check("R3 rand", 8'($urandom), (k % 4 == 0) ? int'($urandom_range(7)) : -1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule